// File: doc/BRIEF.md
# Interruptible Refresh Row Sequencer

This block lives on the memory-array side of a DRAM device and supplies the row address for refresh. Each refresh command from the controller covers a bundle of consecutive rows, and the block steps through those rows one at a time. Each row takes a programmable number of clock cycles, which stands in for the row cycle time. A single run/pause level from the controller, `refr_run_i`, makes the bundle interruptible. A low level is the pause request. It takes effect only at the next row boundary, so a row that has already started always finishes. While the block is paused, the row address counter is frozen. When the level returns high, refresh continues with the next row of the same bundle. The controller gets nothing back on this line. The block only raises a one-cycle completion pulse after the last row of the bundle.

The sequencer has three states. `RP_IDLE` waits for a refresh command. `RP_ROW` runs one row. `RP_HOLD` parks the sequencer at a row boundary. The transitions are:
- **accept-run** (`RP_IDLE`→`RP_ROW`): a command arrives while the run level is high.
- **accept-held** (`RP_IDLE`→`RP_HOLD`): a command arrives while the run level is low.
- **next-row** (`RP_ROW`→`RP_ROW`): a row that is not the last one finishes and the run level is high.
- **pause** (`RP_ROW`→`RP_HOLD`): a row that is not the last one finishes and the run level is low.
- **finish** (`RP_ROW`→`RP_IDLE`): the last row finishes, whatever the run level.
- **resume** (`RP_HOLD`→`RP_ROW`): the run level returns high.

The row address counts upward through the whole array and wraps to zero after the top row. At density changes only the bundle-size parameter changes: 1, 2, 4 or 8 rows.

Top module: `refpause_addr_gen`

## Requirements
- R1: After reset the row address is 0 and `row_busy_o`, `row_held_o` and `bundle_done_o` are all 0.
- R2: The first row refreshed after reset is row 0. Each later row start presents the previous row address plus one on `row_addr_o`.
- R3: Each row keeps `row_busy_o` high for exactly `row_time_i` cycles. A value of 0 counts as 1 cycle.
- R4: A bundle refreshes exactly `BUNDLE_ROWS` rows. `bundle_done_o` is high for exactly one cycle, in the cycle after the last row ends, with `row_busy_o` low.
- R5: If `refr_run_i` goes low during a row, that row still runs for its full length. If it was not the last row of the bundle, `row_held_o` rises when the row ends. If it was the last row, the bundle finishes.
- R6: While `row_held_o` is high, `row_addr_o` keeps the address of the last finished row.
- R7: When `refr_run_i` returns high during a hold, the next row starts one cycle later at the next address. The bundle still totals `BUNDLE_ROWS` rows.
- R8: A refresh command (`refr_go_i` high) that arrives while a bundle is unfinished is ignored. It does not add rows and does not start a new bundle afterwards.
- R9: A refresh command that arrives while `refr_run_i` is low is accepted straight into the hold state. No row starts until `refr_run_i` is high.
- R10: After row `NUM_ROWS-1` the next row refreshed is row 0.
- R11: A row never starts, and the row address never changes, in a cycle that follows a low `refr_run_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refr_go_i | input | 1 | Refresh command pulse; starts one bundle when the block is idle |
| refr_run_i | input | 1 | Run level from the controller; low requests a pause at the next row boundary |
| row_time_i | input | CYC_W | Cycles per row refresh (0 is treated as 1) |
| row_addr_o | output | ROW_W | Address of the row being refreshed or last refreshed |
| row_busy_o | output | 1 | A row refresh is in progress |
| row_held_o | output | 1 | The bundle is parked at a row boundary |
| bundle_done_o | output | 1 | One-cycle pulse after the last row of a bundle |

## Verification
The hardest situations to reach from the ports are a pause request that arrives inside a row, and a pause that lands exactly on the bundle's final row. In both cases the run level must drop while `row_busy_o` is high, and the outcome (hold or finish) depends only on the row's position in the bundle. The stimulus table therefore names the row index at which the run level falls. The bench watches for that row's start and lowers the level within the same cycle, which covers one-cycle rows. The entries cover a pause on the first row, on a middle row and on the last row. A separate directed case sends the command while the run level is already low, and cycle-length rows are run around the address array until it wraps.

// File: rtl/refpause_pkg.sv
package refpause_pkg;

    typedef enum logic [1:0] {
        RP_IDLE = 2'd0,
        RP_ROW  = 2'd1,
        RP_HOLD = 2'd2
    } rp_state_e;

endpackage

// File: rtl/refpause_row_timer.sv
module refpause_row_timer #(
    parameter int CYC_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CYC_W-1:0] row_time_i,
    output logic             last_o
);

    logic [CYC_W-1:0] cnt_q;
    logic [CYC_W-1:0] span;

    always_comb begin
        span   = (row_time_i == '0) ? CYC_W'(1) : row_time_i;
        last_o = run_i && (cnt_q == span - CYC_W'(1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + CYC_W'(1);
        end
    end

endmodule

// File: rtl/refpause_row_counter.sv
module refpause_row_counter #(
    parameter int NUM_ROWS = 8192,
    parameter int ROW_W    = $clog2(NUM_ROWS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_req_i,
    input  logic             run_i,
    output logic [ROW_W-1:0] row_addr_o
);

    localparam logic [ROW_W-1:0] TOP_ROW = ROW_W'(NUM_ROWS - 1);

    logic             step;
    logic             primed_q;
    logic [ROW_W-1:0] addr_q;

    // increment request gated by the run level: frozen while it is low
    assign step       = step_req_i & run_i;
    assign row_addr_o = addr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            addr_q   <= '0;
            primed_q <= 1'b0;
        end else if (step) begin
            if (!primed_q) begin
                primed_q <= 1'b1;
            end else if (addr_q == TOP_ROW) begin
                addr_q <= '0;
            end else begin
                addr_q <= addr_q + ROW_W'(1);
            end
        end
    end

endmodule

// File: rtl/refpause_bundle_count.sv
module refpause_bundle_count #(
    parameter int BUNDLE_ROWS = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic adv_i,
    output logic last_o
);

    generate
        if (BUNDLE_ROWS == 1) begin : g_single
            logic unused_ok;
            assign unused_ok = clk_i ^ rst_ni ^ clear_i ^ adv_i;
            assign last_o    = 1'b1 | unused_ok;
        end else begin : g_multi
            localparam int IDX_W = $clog2(BUNDLE_ROWS);
            localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BUNDLE_ROWS - 1);

            logic [IDX_W-1:0] idx_q;

            assign last_o = (idx_q == LAST_IDX);

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    idx_q <= '0;
                end else if (clear_i) begin
                    idx_q <= '0;
                end else if (adv_i) begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/refpause_addr_gen.sv
module refpause_addr_gen
    import refpause_pkg::*;
#(
    parameter int NUM_ROWS    = 8192,
    parameter int BUNDLE_ROWS = 4,
    parameter int CYC_W       = 6,
    parameter int ROW_W       = $clog2(NUM_ROWS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             refr_go_i,
    input  logic             refr_run_i,
    input  logic [CYC_W-1:0] row_time_i,
    output logic [ROW_W-1:0] row_addr_o,
    output logic             row_busy_o,
    output logic             row_held_o,
    output logic             bundle_done_o
);

    rp_state_e state_q, state_d;
    logic      done_q;
    logic      row_req;
    logic      row_start;
    logic      bundle_clr;
    logic      bundle_adv;
    logic      finish;
    logic      last_cyc;
    logic      last_row;

    // next-state process
    always_comb begin
        state_d    = state_q;
        row_req    = 1'b0;
        bundle_clr = 1'b0;
        bundle_adv = 1'b0;
        finish     = 1'b0;
        unique case (state_q)
            RP_IDLE: begin
                if (refr_go_i) begin
                    bundle_clr = 1'b1;
                    row_req    = 1'b1;
                    state_d    = refr_run_i ? RP_ROW : RP_HOLD;
                end
            end
            RP_ROW: begin
                if (last_cyc) begin
                    if (last_row) begin
                        finish  = 1'b1;
                        state_d = RP_IDLE;
                    end else begin
                        bundle_adv = 1'b1;
                        row_req    = 1'b1;
                        state_d    = refr_run_i ? RP_ROW : RP_HOLD;
                    end
                end
            end
            RP_HOLD: begin
                row_req = 1'b1;
                if (refr_run_i) begin
                    state_d = RP_ROW;
                end
            end
            default: state_d = RP_IDLE;
        endcase
    end

    assign row_start = row_req & refr_run_i;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RP_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
        end
    end

    // output process
    always_comb begin
        row_busy_o    = (state_q == RP_ROW);
        row_held_o    = (state_q == RP_HOLD);
        bundle_done_o = done_q;
    end

    refpause_row_timer #(
        .CYC_W(CYC_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (row_start),
        .run_i      (row_busy_o),
        .row_time_i (row_time_i),
        .last_o     (last_cyc)
    );

    refpause_row_counter #(
        .NUM_ROWS(NUM_ROWS),
        .ROW_W   (ROW_W)
    ) u_rows (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_req_i (row_req),
        .run_i      (refr_run_i),
        .row_addr_o (row_addr_o)
    );

    refpause_bundle_count #(
        .BUNDLE_ROWS(BUNDLE_ROWS)
    ) u_bundle (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (bundle_clr),
        .adv_i   (bundle_adv),
        .last_o  (last_row)
    );

endmodule

// File: rtl/refpause_addr_gen_chk.sv
module refpause_addr_gen_chk #(
    parameter int NUM_ROWS = 8192,
    parameter int ROW_W    = $clog2(NUM_ROWS)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             refr_run_i,
    input logic [ROW_W-1:0] row_addr_o,
    input logic             row_busy_o,
    input logic             row_held_o,
    input logic             bundle_done_o
);

    localparam logic [ROW_W-1:0] TOP_ROW = ROW_W'(NUM_ROWS - 1);

    p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bundle_done_o |=> !bundle_done_o);

    p_done_after_row_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bundle_done_o |-> ($past(row_busy_o) && !row_busy_o));

    p_hold_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_held_o && !refr_run_i) |=> (row_held_o && $stable(row_addr_o)));

    p_start_needs_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(row_busy_o) |-> $past(refr_run_i));

    p_addr_moves_on_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(row_addr_o) |-> ($past(refr_run_i) && row_busy_o));

    p_addr_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(row_addr_o) |->
            (($past(row_addr_o) == TOP_ROW) ? (row_addr_o == '0)
                                            : (row_addr_o == $past(row_addr_o) + ROW_W'(1))));

endmodule

bind refpause_addr_gen refpause_addr_gen_chk #(
    .NUM_ROWS(NUM_ROWS),
    .ROW_W   (ROW_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .refr_run_i    (refr_run_i),
    .row_addr_o    (row_addr_o),
    .row_busy_o    (row_busy_o),
    .row_held_o    (row_held_o),
    .bundle_done_o (bundle_done_o)
);

// File: tb/sim_refpause_addr_gen.sv
module sim_refpause_addr_gen;

    localparam int NR = 64;
    localparam int B  = 4;
    localparam int CW = 6;
    localparam int RW = $clog2(NR);

    // cycles per row, row index where the run level drops (-1 none), hold length, extra command
    localparam int VEC [8][4] = '{
        '{3, -1, 0, 0},
        '{1, -1, 0, 0},
        '{0, -1, 0, 0},
        '{4,  1, 3, 0},
        '{1,  0, 2, 0},
        '{2,  3, 1, 0},
        '{5,  2, 4, 1},
        '{2, -1, 0, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic          run = 1'b1;
    logic [CW-1:0] rtime = CW'(2);
    logic [RW-1:0] addr;
    logic          busy, held, bdone;

    int checks = 0;
    int failures = 0;
    int cyc_n = 0;
    int exp_next = 0;

    refpause_addr_gen #(
        .NUM_ROWS(NR), .BUNDLE_ROWS(B), .CYC_W(CW)
    ) u0 (
        .clk_i(clk), .rst_ni(rst_n), .refr_go_i(go), .refr_run_i(run),
        .row_time_i(rtime), .row_addr_o(addr), .row_busy_o(busy),
        .row_held_o(held), .bundle_done_o(bdone)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 150000) begin
            failures++;
            $display("FAIL watchdog act=%0d exp<=150000", cyc_n);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_bundle(int cyc, int prow, int plen, int xp, string atag);
        int eff = (cyc == 0) ? 1 : cyc;
        int rows = 0;
        int len = 0;
        int pausing = 0;
        int held_n = 0;
        bit armed = 0;
        bit pb = 0;
        bit fin = 0;
        logic [RW-1:0] pa = '0;
        @(negedge clk);
        rtime = CW'(cyc);
        go = 1'b1;
        run = 1'b1;
        for (int it = 0; it < 500 && !fin; it++) begin
            @(negedge clk);
            go = 1'b0;
            if (busy && (!pb || addr != pa)) begin
                if (pb) chk(len == eff, "R3", "row length", len, eff);
                if (held_n > 0) begin
                    chk(held_n == plen, "R7", "hold cycles before resume", held_n, plen);
                    held_n = 0;
                end
                chk(int'(addr) == exp_next, (rows == 0) ? atag : "R7", "row address", int'(addr), exp_next);
                exp_next = (exp_next + 1) % NR;
                rows++;
                len = 1;
                if (rows - 1 == prow) begin
                    run = 1'b0;
                    pausing = plen;
                    armed = 1;
                end
                if (xp != 0 && rows == 2) go = 1'b1;
            end else if (busy) begin
                len++;
            end else if (pb) begin
                chk(len == eff, "R3", "row length", len, eff);
                if (armed && rows < B) chk(held, "R5", "hold after paused row", int'(held), 1);
                armed = 0;
            end
            if (held) begin
                chk(addr == pa || !pb, "R6", "held address", int'(addr), int'(pa));
                chk(!busy, "R11", "no row while run low", int'(busy), 0);
                held_n++;
                if (pausing > 1) pausing--;
                else run = 1'b1;
            end
            if (bdone) begin
                fin = 1;
                chk(rows == B, "R4", "rows in bundle", rows, B);
                chk(!busy, "R4", "busy with done", int'(busy), 0);
            end
            pb = busy;
            if (!held) pa = addr;
        end
        chk(fin, "R4", "bundle completion seen", int'(fin), 1);
        run = 1'b1;
        @(negedge clk);
        chk(!bdone, "R4", "done pulse width", int'(bdone), 0);
        if (xp != 0) begin
            @(negedge clk);
            @(negedge clk);
            chk(!busy && !held, "R8", "command during bundle ignored", int'(busy || held), 0);
        end
    endtask

    initial begin
        logic [RW-1:0] a0;
        repeat (3) @(negedge clk);
        chk(addr == '0 && !busy && !held && !bdone, "R1", "reset outputs", int'(addr) + int'(busy) + int'(held) + int'(bdone), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(addr == '0 && !busy && !held && !bdone, "R1", "idle after reset", int'(addr) + int'(busy) + int'(held), 0);

        for (int v = 0; v < 8; v++) begin
            run_bundle(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], "R2");
        end

        // command while run level is low
        @(negedge clk);
        a0 = addr;
        run = 1'b0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        rtime = CW'(1);
        chk(held && !busy, "R9", "accepted into hold", int'(held), 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(held && !busy && addr == a0, "R9", "no row while run low", int'(addr), int'(a0));
        end
        run = 1'b1;
        @(negedge clk);
        chk(busy && int'(addr) == exp_next, "R9", "first row after release", int'(addr), exp_next);
        for (int k = 0; k < 20 && !bdone; k++) @(negedge clk);
        chk(bdone, "R9", "held bundle finishes", int'(bdone), 1);
        exp_next = (exp_next + B) % NR;

        // wrap of the address counter
        for (int k = 0; k < 10; k++) begin
            run_bundle(1, -1, 0, 0, "R10");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule